// File: doc/BRIEF.md
# Double-Buffered Grayscale PWM Engine

This block turns per-channel grayscale levels for a multiplexed LED matrix into per-channel on/off drive enables. It keeps two frame banks of `GS_W`-bit levels, each sized for `NUM_CH` channels by `MAX_LINES` scan lines. One bank is on display while the other accepts writes. A sync pulse makes the banks trade roles. The swap waits for the scan to return to line 0, so a frame is never torn part-way through a scan.

The grayscale clock `gclk` is sampled in the system clock domain. Its rising edges, or both of its edges, become count ticks. A grayscale counter spans `2^GS_W` ticks per line, and each channel is driven while the counter is below its level. A line counter then steps through lines 0 to `last_line` and wraps.

When power-save is enabled and a frame made only of zero levels is swapped in, the block enters a dark sleep state. It leaves that state on the first non-zero write.

The control state machine has three states:
- IDLE: dark, from reset until the first swap.
- SCAN: counters running.
- SLEEP: dark, counters held at zero, `psave` high.

Its transitions are:
- `first_swap`: IDLE to SCAN, or IDLE to SLEEP when the new frame is all zero.
- `swap_to_zero`: SCAN to SLEEP.
- `swap_keep`: SCAN to SCAN.
- `wake`: SLEEP to SCAN, on a valid non-zero write, on a swap to a non-zero frame, or when `psave_en` is cleared.
- `swap_sleep`: SLEEP to SLEEP, on a swap to another zero frame.

Top module: `gs_pwm_engine`

## Requirements
- R1: After reset, `ch_on` is all zero, `psave` is 0 and `cur_line` is 0. They stay so until the first `vsync` has been taken.
- R2: With `dual_edge`=0, each rising edge of `gclk` is one tick. A channel with level V is driven for V ticks in each line, which is V×(gclk period) system clocks.
- R3: With `dual_edge`=1, both edges of `gclk` are ticks, so the same level lasts half as many system clocks at the same gclk rate.
- R4: A channel whose level is 0 is never driven.
- R5: `cur_line` advances by one after `2^GS_W` ticks. After `last_line` (clamped to `MAX_LINES`-1) it wraps to 0, and no other step occurs.
- R6: Writes land in the bank not on display. Lines already on display keep their levels while the other bank is being written.
- R7: A `vsync` pulse during SCAN takes effect when the scan next wraps to line 0. The remaining lines of the current frame show the old levels, and the new frame starts at line 0. In IDLE or SLEEP the swap is immediate.
- R8: A write with `wr_line` > `last_line`, or with `wr_ch` >= `NUM_CH`, is ignored. A non-zero level sent to such an address does not wake the block from SLEEP.
- R9: With `psave_en`=1, if no non-zero level was validly written since the previous swap, the swap sets `psave`=1. While `psave` is 1, `ch_on` is all zero and `cur_line` is 0.
- R10: A valid write of a non-zero level clears `psave` at the next clock edge.
- R11: With `psave_en`=0, `psave` stays 0 even when an all-zero frame is displayed, and that frame drives no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gclk | input | 1 | Grayscale reference clock, sampled by `clk` |
| dual_edge | input | 1 | 1: count both gclk edges, 0: rising edges only |
| psave_en | input | 1 | 1: allow sleep on all-zero frames |
| last_line | input | LINE_W | Index of the last scan line |
| wr_en | input | 1 | Write strobe for one level |
| wr_line | input | LINE_W | Line address of the write |
| wr_ch | input | CH_AW | Channel address of the write (one bit wider than needed) |
| wr_data | input | GS_W | Grayscale level |
| vsync | input | 1 | Request to swap banks |
| ch_on | output | NUM_CH | Per-channel drive enable |
| cur_line | output | LINE_W | Line currently scanned |
| psave | output | 1 | Power-save flag |

## Verification
The bench measures the number of system clocks each channel is driven in each line and compares it against levels from its own frame model. Frames are built so that levels vary with line and channel and include zeros. This way, line mix-ups, bank mix-ups and off-by-one on-times all show up as different counts.

The same measurement is repeated in single-edge and dual-edge mode; only the tick rate changes the counts, which separates the two edge modes. A `vsync` issued mid-frame, with writes in progress, is followed by checks of the old frame's remaining lines and then of the new frame from line 0. This separates a deferred swap from a torn one. All-zero frames are sent with power-save enabled and disabled, and are followed by out-of-range and valid non-zero writes. These tell apart sleeping, waking and the ignoring of bad addresses.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_SLEEP = 2'd2
    } scan_state_t;
endpackage

// File: rtl/gs_edge_tick.sv
// Samples the grayscale clock into the system domain and emits one-cycle ticks.
module gs_edge_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gclk,
    input  logic dual_edge,
    output logic tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= gclk;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], gclk};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign tick = dual_edge ? (sync_q[SYNC_STAGES-1] ^ prev_q)
                            : (sync_q[SYNC_STAGES-1] & ~prev_q);
endmodule

// File: rtl/gs_scan_counter.sv
// Grayscale tick counter per line and scan-line counter.
module gs_scan_counter #(
    parameter int GS_W   = 16,
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [LINE_W-1:0] last_line,
    output logic [GS_W-1:0]   gs_cnt,
    output logic [LINE_W-1:0] line,
    output logic              frame_wrap
);
    localparam logic [GS_W-1:0] GS_TOP = '1;

    logic line_done;
    logic at_last;

    assign line_done  = run && tick && (gs_cnt == GS_TOP);
    assign at_last    = (line >= last_line);
    assign frame_wrap = line_done && at_last;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            gs_cnt <= '0;
            line   <= '0;
        end else if (tick) begin
            gs_cnt <= gs_cnt + 1'b1;
            if (line_done) begin
                line <= at_last ? '0 : line + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gs_frame_store.sv
// Two frame banks; one written, one read a whole line at a time.
module gs_frame_store #(
    parameter int NUM_CH    = 16,
    parameter int GS_W      = 16,
    parameter int MAX_LINES = 48,
    localparam int LINE_W   = $clog2(MAX_LINES),
    localparam int CH_IW    = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic                   wr_bank,
    input  logic [LINE_W-1:0]      wr_line,
    input  logic [CH_IW-1:0]       wr_ch,
    input  logic [GS_W-1:0]        wr_data,
    input  logic                   rd_bank,
    input  logic [LINE_W-1:0]      rd_line,
    output logic [NUM_CH*GS_W-1:0] rd_data
);
    logic [GS_W-1:0] mem [2][MAX_LINES][NUM_CH];

    always_ff @(posedge clk) begin
        if (we) mem[wr_bank][wr_line][wr_ch] <= wr_data;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_rd
        assign rd_data[c*GS_W +: GS_W] = mem[rd_bank][rd_line][c];
    end
endmodule

// File: rtl/gs_pwm_engine.sv
module gs_pwm_engine
    import gs_pwm_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int GS_W      = 16,
    parameter int MAX_LINES = 48,
    localparam int LINE_W   = $clog2(MAX_LINES),
    localparam int CH_IW    = $clog2(NUM_CH),
    localparam int CH_AW    = CH_IW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gclk,
    input  logic              dual_edge,
    input  logic              psave_en,
    input  logic [LINE_W-1:0] last_line,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [CH_AW-1:0]  wr_ch,
    input  logic [GS_W-1:0]   wr_data,
    input  logic              vsync,
    output logic [NUM_CH-1:0] ch_on,
    output logic [LINE_W-1:0] cur_line,
    output logic              psave
);
    localparam logic [LINE_W-1:0] LAST_MAX = LINE_W'(MAX_LINES - 1);
    localparam logic [CH_AW-1:0]  CH_LIM   = CH_AW'(NUM_CH);

    scan_state_t state_q, state_d;

    logic                   tick, frame_wrap, run;
    logic                   swap_req, swap_now, disp_bank;
    logic                   nz_wr, nz_pending, wr_ok, wr_nz, next_dark;
    logic [GS_W-1:0]        gs_cnt;
    logic [LINE_W-1:0]      eff_last, line;
    logic [NUM_CH*GS_W-1:0] rd_data;
    logic [NUM_CH-1:0]      on_d;

    assign eff_last   = (last_line > LAST_MAX) ? LAST_MAX : last_line;
    assign wr_ok      = wr_en && (wr_line <= eff_last) && (wr_ch < CH_LIM);
    assign wr_nz      = wr_ok && (wr_data != '0);
    assign run        = (state_q == ST_SCAN);
    assign swap_now   = swap_req && (!run || frame_wrap);
    assign nz_pending = nz_wr || wr_nz;
    assign next_dark  = psave_en && !nz_pending;

    gs_edge_tick #(.SYNC_STAGES(2)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .gclk      (gclk),
        .dual_edge (dual_edge),
        .tick      (tick)
    );

    gs_scan_counter #(.GS_W(GS_W), .LINE_W(LINE_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick),
        .last_line  (eff_last),
        .gs_cnt     (gs_cnt),
        .line       (line),
        .frame_wrap (frame_wrap)
    );

    gs_frame_store #(.NUM_CH(NUM_CH), .GS_W(GS_W), .MAX_LINES(MAX_LINES)) u_store (
        .clk     (clk),
        .we      (wr_ok),
        .wr_bank (~disp_bank),
        .wr_line (wr_line),
        .wr_ch   (wr_ch[CH_IW-1:0]),
        .wr_data (wr_data),
        .rd_bank (disp_bank),
        .rd_line (line),
        .rd_data (rd_data)
    );

    // Swap request, bank pointer and zero-frame tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_req  <= 1'b0;
            disp_bank <= 1'b0;
            nz_wr     <= 1'b0;
        end else begin
            if (swap_now) begin
                swap_req  <= vsync;
                disp_bank <= ~disp_bank;
                nz_wr     <= 1'b0;
            end else begin
                if (vsync) swap_req <= 1'b1;
                if (wr_nz) nz_wr    <= 1'b1;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (swap_now) state_d = next_dark ? ST_SLEEP : ST_SCAN;   // first_swap
            end
            ST_SCAN: begin
                if (swap_now) state_d = next_dark ? ST_SLEEP : ST_SCAN;   // swap_to_zero / swap_keep
            end
            ST_SLEEP: begin
                if (swap_now && next_dark)                state_d = ST_SLEEP; // swap_sleep
                else if (swap_now || wr_nz || !psave_en) state_d = ST_SCAN;  // wake
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Per-channel comparison against the grayscale count.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        assign on_d[c] = (rd_data[c*GS_W +: GS_W] > gs_cnt);
    end

    // Outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) ch_on <= '0;
        else        ch_on <= run ? on_d : '0;
    end

    assign psave    = (state_q == ST_SLEEP);
    assign cur_line = line;
endmodule

// File: rtl/gs_pwm_engine_chk.sv
module gs_pwm_engine_chk #(
    parameter int NUM_CH = 16,
    parameter int GS_W   = 16,
    parameter int LINE_W = 6,
    parameter int CH_AW  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psave_en,
    input logic              psave,
    input logic [NUM_CH-1:0] ch_on,
    input logic [LINE_W-1:0] cur_line,
    input logic [LINE_W-1:0] last_line,
    input logic              wr_en,
    input logic [LINE_W-1:0] wr_line,
    input logic [CH_AW-1:0]  wr_ch,
    input logic [GS_W-1:0]   wr_data,
    input logic              disp_bank
);
    // R9
    psave_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psave |-> (ch_on == '0 && cur_line == '0));

    // R11
    psave_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psave) |-> $past(psave_en));

    // R5
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_line) |-> (cur_line == '0 || cur_line == ($past(cur_line) + 1'b1)));

    // R10
    psave_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psave && wr_en && (wr_line <= last_line) && (wr_ch < CH_AW'(NUM_CH)) && (wr_data != '0))
        |=> !psave);

    // R7
    swap_line0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_bank) |-> (cur_line == '0));
endmodule

bind gs_pwm_engine gs_pwm_engine_chk #(
    .NUM_CH (NUM_CH),
    .GS_W   (GS_W),
    .LINE_W (LINE_W),
    .CH_AW  (CH_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psave_en  (psave_en),
    .psave     (psave),
    .ch_on     (ch_on),
    .cur_line  (cur_line),
    .last_line (last_line),
    .wr_en     (wr_en),
    .wr_line   (wr_line),
    .wr_ch     (wr_ch),
    .wr_data   (wr_data),
    .disp_bank (disp_bank)
);

// File: tb/test_gs_pwm_engine.sv
`timescale 1ns/1ps
module test_gs_pwm_engine;
    localparam int NCH    = 16;
    localparam int GSW    = 4;
    localparam int MLINES = 8;
    localparam int LW     = $clog2(MLINES);
    localparam int CAW    = $clog2(NCH) + 1;
    localparam int LAST   = 3;
    localparam int HALF_G = 3;          // gclk toggles every 3 system clocks

    logic clk = 1'b0, rst_n = 1'b0, gclk = 1'b0;
    logic dual_edge = 1'b0, psave_en = 1'b0, wr_en = 1'b0, vsync = 1'b0;
    logic [LW-1:0]  last_line = LW'(LAST), wr_line = '0;
    logic [CAW-1:0] wr_ch = '0;
    logic [GSW-1:0] wr_data = '0;
    logic [NCH-1:0] ch_on;
    logic [LW-1:0]  cur_line;
    logic           psave;

    int checks = 0, failures = 0;
    int q_line[$], q_cnt[$];
    string q_tag[$];
    int acc[NCH];
    bit psave_seen = 1'b0;

    always #2.5 clk = ~clk;

    gs_pwm_engine #(.NUM_CH(NCH), .GS_W(GSW), .MAX_LINES(MLINES)) i_gs_pwm_engine (
        .clk(clk), .rst_n(rst_n), .gclk(gclk), .dual_edge(dual_edge),
        .psave_en(psave_en), .last_line(last_line), .wr_en(wr_en),
        .wr_line(wr_line), .wr_ch(wr_ch), .wr_data(wr_data), .vsync(vsync),
        .ch_on(ch_on), .cur_line(cur_line), .psave(psave)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int gsv(input int f, input int l, input int c);
        if (f < 0) return 0;
        return (f * 7 + l * 5 + c * 3) % 16;
    endfunction

    // gclk source, driven away from the active edge.
    initial begin
        forever begin
            repeat (HALF_G) @(negedge clk);
            gclk = ~gclk;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Monitor: per-line on-time measurement, pops the scoreboard.
    initial begin
        int lp1, lp2;
        lp1 = 0; lp2 = 0;
        foreach (acc[i]) acc[i] = 0;
        forever begin
            @(negedge clk);
            if (psave) psave_seen = 1'b1;
            if (!rst_n) begin
                lp1 = 0; lp2 = 0;
                foreach (acc[i]) acc[i] = 0;
            end else begin
                if (lp1 != lp2) begin
                    // R5: the only legal steps are +1 or wrap from the last line.
                    chk(lp1 == ((lp2 == LAST) ? 0 : lp2 + 1), "R5", "line step", lp1,
                        (lp2 == LAST) ? 0 : lp2 + 1);
                    if (q_line.size() != 0 && q_line[0] == lp2) begin
                        int bad_ch, bad_act, bad_exp;
                        string tag;
                        bad_ch = -1; bad_act = 0; bad_exp = 0;
                        void'(q_line.pop_front());
                        tag = q_tag.pop_front();
                        for (int c = 0; c < NCH; c++) begin
                            int e;
                            e = q_cnt.pop_front();
                            if (acc[c] != e && bad_ch < 0) begin
                                bad_ch = c; bad_act = acc[c]; bad_exp = e;
                            end
                        end
                        chk(bad_ch < 0, tag, $sformatf("line %0d ch %0d on-clocks", lp2, bad_ch),
                            bad_act, bad_exp);
                    end
                    foreach (acc[i]) acc[i] = 0;
                end
                for (int c = 0; c < NCH; c++) if (ch_on[c]) acc[c]++;
                lp2 = lp1;
                lp1 = int'(cur_line);
            end
        end
    end

    // Driver: pushes expected on-times for lines first..LAST of frame f.
    task automatic push_frame(input int f, input int first, input int per, input string tag);
        for (int l = first; l <= LAST; l++) begin
            q_line.push_back(l);
            for (int c = 0; c < NCH; c++) q_cnt.push_back(gsv(f, l, c) * per);
            q_tag.push_back(tag);
        end
    endtask

    task automatic write_one(input int l, input int c, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_line = LW'(l); wr_ch = CAW'(c); wr_data = GSW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_frame(input int f);
        for (int l = 0; l <= LAST; l++)
            for (int c = 0; c < NCH; c++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_line = LW'(l); wr_ch = CAW'(c); wr_data = GSW'(gsv(f, l, c));
            end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_vsync();
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
    endtask

    task automatic wait_line(input int n);
        int prev;
        prev = int'(cur_line);
        forever begin
            @(negedge clk);
            if (int'(cur_line) == n && prev != n) break;
            prev = int'(cur_line);
        end
    endtask

    task automatic drain();
        while (q_line.size() != 0) @(negedge clk);
    endtask

    initial begin
        bit dark_ok;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ch_on == '0, "R1", "ch_on after reset", int'(ch_on), 0);
        chk(psave == 1'b0, "R1", "psave after reset", int'(psave), 0);
        chk(cur_line == '0, "R1", "cur_line after reset", int'(cur_line), 0);
        dark_ok = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (ch_on != '0 || cur_line != '0) dark_ok = 1'b0;
        end
        chk(dark_ok, "R1", "dark before first vsync", int'(dark_ok), 1);

        // R2/R4: first frame, single-edge ticks of 6 clocks.
        write_frame(0);
        pulse_vsync();
        push_frame(0, 0, 2 * HALF_G, "R2");
        drain();

        // R6/R7: mid-frame writes and vsync; old lines 2..3 then new frame from line 0.
        wait_line(1);
        push_frame(0, 2, 2 * HALF_G, "R6");
        write_frame(1);
        pulse_vsync();
        push_frame(1, 0, 2 * HALF_G, "R7");
        drain();

        // R3: dual-edge ticks halve the on-time.
        dual_edge = 1'b1;
        write_frame(2);
        wait_line(1);
        pulse_vsync();
        push_frame(2, 0, HALF_G, "R3");
        drain();
        dual_edge = 1'b0;

        // R9: zero frame with power-save enabled.
        psave_en = 1'b1;
        write_frame(-1);
        wait_line(1);
        pulse_vsync();
        for (int i = 0; i < 2000 && !psave; i++) @(negedge clk);
        chk(psave == 1'b1, "R9", "psave after zero-frame swap", int'(psave), 1);
        dark_ok = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (ch_on != '0 || cur_line != '0) dark_ok = 1'b0;
        end
        chk(dark_ok, "R9", "dark and held during sleep", int'(dark_ok), 1);

        // R8: out-of-range addresses are ignored.
        write_one(5, 0, 9);
        @(negedge clk);
        chk(psave == 1'b1, "R8", "psave after bad-line write", int'(psave), 1);
        write_one(0, NCH, 9);
        @(negedge clk);
        chk(psave == 1'b1, "R8", "psave after bad-channel write", int'(psave), 1);

        // R10: valid non-zero write wakes at the next edge.
        @(negedge clk);
        wr_en = 1'b1; wr_line = LW'(2); wr_ch = CAW'(4); wr_data = GSW'(7);
        @(negedge clk);
        wr_en = 1'b0;
        chk(psave == 1'b0, "R10", "psave after valid write", int'(psave), 0);
        write_frame(3);
        wait_line(1);
        pulse_vsync();
        push_frame(3, 0, 2 * HALF_G, "R10");
        drain();

        // R11: zero frame with power-save disabled.
        psave_en = 1'b0;
        write_frame(-1);
        wait_line(1);
        psave_seen = 1'b0;
        pulse_vsync();
        push_frame(-1, 0, 2 * HALF_G, "R11");
        drain();
        chk(!psave_seen, "R11", "psave while disabled", int'(psave_seen), 0);

        chk(q_line.size() == 0, "R7", "scoreboard drained", q_line.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule